// File: doc/BRIEF.md
# USB NRZI Line Decoder with Bit Unstuffing

This block sits behind a USB low/full-speed symbol sampler. Each cycle the sampler may present one recovered line symbol (J, K, SE0 or SE1) together with a strobe. It also raises a one-cycle start pulse when it sees the start of a packet. The decoder turns the J/K symbols into data bits by NRZI rules and strips the bits that the transmitter stuffed after long runs of ones. It recognises the SE0-then-J ending that closes a packet and reports it as an end-of-packet pulse. It also reports malformed streams: a seventh consecutive one, or an illegal line state. In both cases it drops back to idle and waits for the next start pulse.

The decoder is a three-state machine.
- ST_IDLE: no packet is open. Symbols are ignored here.
- ST_DATA: symbols are decoded into bits.
- ST_EOP: the machine has seen an SE0 and waits for the closing J.

The transitions are:
- start: the start pulse moves any state to ST_DATA.
- se0_seen: ST_DATA to ST_EOP when an SE0 arrives.
- eop_done: ST_EOP to ST_IDLE when a J arrives.
- stuff_fault: ST_DATA to ST_IDLE on a seventh consecutive one.
- line_fault: ST_DATA or ST_EOP to ST_IDLE on an illegal symbol.
- se0_hold: ST_EOP stays in ST_EOP on a further SE0.

Every result is registered and appears exactly one cycle after the strobe that caused it.

Top module: `usb_nrzi_unstuff`

## Requirements
- R1: Symbol codes on sym_code are J=2'b00, K=2'b01, SE0=2'b10 and SE1=2'b11. In ST_DATA a J or K strobed with sym_valid produces bit_valid one cycle later. bit_data is 1 if the symbol equals the previous J/K symbol and 0 if it differs.
- R2: After reset and after each pkt_start, the previous-symbol register holds J. The first K of a packet therefore decodes as 0 and the first J as 1.
- R3: If six consecutive 1 data bits have been output and the next J/K decodes as 0, stuff_pulse is raised instead of bit_valid. The ones count is cleared, and that symbol still becomes the previous symbol for NRZI.
- R4: A decoded 0 that is not a stuff bit is output as data and clears the ones count. Fewer than six ones followed by a 0 never produce a stuff pulse.
- R5: If six consecutive ones have been output and the next J/K decodes as 1, stuff_err is pulsed instead of a bit and the block returns to ST_IDLE.
- R6: An SE0 in ST_DATA produces no output and enters ST_EOP. Further SE0 symbols in ST_EOP produce no output.
- R7: A J received in ST_EOP produces eop_pulse and no data bit, and the block returns to ST_IDLE.
- R8: An SE1 in ST_DATA, or a K or SE1 in ST_EOP, pulses line_err with no data bit and returns the block to ST_IDLE.
- R9: In ST_IDLE, strobed symbols produce no output of any kind.
- R10: All outputs are 0 during reset. In any cycle at most one of bit_valid, stuff_pulse, eop_pulse, stuff_err and line_err is high.
- R11: pkt_start takes priority in every state. It enters ST_DATA, clears the ones count, resets the previous symbol to J and discards a symbol strobed in the same cycle, with no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_valid | input | 1 | One-cycle strobe: sym_code holds a new line symbol |
| sym_code | input | 2 | Line symbol code (J, K, SE0, SE1) |
| pkt_start | input | 1 | One-cycle packet start pulse |
| bit_valid | output | 1 | A decoded data bit is on bit_data |
| bit_data | output | 1 | Decoded data bit |
| stuff_pulse | output | 1 | A stuffed bit was removed |
| eop_pulse | output | 1 | End of packet detected |
| stuff_err | output | 1 | Seventh consecutive one seen |
| line_err | output | 1 | Illegal line state within a packet |

## Verification
The bench targets the six-ones boundary from both sides.
- Five ones followed by a zero must stay data. A design that stuffs one bit early would turn that zero into a stuff pulse.
- Six ones followed by a one must raise stuff_err. A design that stuffs one bit late would emit a seventh data bit instead.

A stuffed bit is followed by a symbol equal to the stuffed one. A design that does not let the stuffed symbol update the NRZI reference would decode that symbol as 0 instead of 1.

Several other cases are covered:
- a restart in mid-packet coinciding with a symbol strobe;
- a K inside the end-of-packet wait;
- repeated SE0 symbols;
- symbols in idle.

A decoder that forgot to reset its previous symbol, or that leaked bits for line states, would produce extra or mis-valued bit strobes in these cases.

// File: rtl/usb_nrzi_pkg.sv
package usb_nrzi_pkg;

    typedef enum logic [1:0] {
        SYM_J   = 2'b00,
        SYM_K   = 2'b01,
        SYM_SE0 = 2'b10,
        SYM_SE1 = 2'b11
    } line_sym_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_DATA = 2'b01,
        ST_EOP  = 2'b10
    } dec_state_t;

    typedef struct packed {
        logic bit_valid;
        logic bit_data;
        logic stuff;
        logic eop;
        logic stuff_err;
        logic line_err;
    } dec_out_t;

    localparam dec_out_t DEC_OUT_NONE = '0;

endpackage

// File: rtl/usb_nrzi_prevsym.sv
module usb_nrzi_prevsym
    import usb_nrzi_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  logic      advance,
    input  line_sym_t sym,
    output logic      same_as_prev
);

    line_sym_t prev_q;

    // Idle line state is J, so the reference restarts at J.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= SYM_J;
        end else if (restart) begin
            prev_q <= SYM_J;
        end else if (advance) begin
            prev_q <= sym;
        end
    end

    assign same_as_prev = (sym == prev_q);

    // R1: only J or K may ever become the NRZI reference
    assert_ref_is_jk_R1: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> (sym == SYM_J || sym == SYM_K));

endmodule

// File: rtl/usb_nrzi_runlen.sv
module usb_nrzi_runlen #(
    parameter int RUN_LIMIT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic incr,
    output logic at_limit
);

    localparam int CNT_W = $clog2(RUN_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(RUN_LIMIT);

    logic [CNT_W-1:0] ones_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (clear) begin
            ones_q <= '0;
        end else if (incr) begin
            ones_q <= ones_q + 1'b1;
        end
    end

    assign at_limit = (ones_q == LIMIT_V);

    // R3: the run count never passes the stuffing limit
    assert_run_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= LIMIT_V);

    // R5: a one at the limit is an error, never a further increment
    assert_no_incr_at_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        incr |-> !at_limit);

endmodule

// File: rtl/usb_nrzi_unstuff.sv
module usb_nrzi_unstuff
    import usb_nrzi_pkg::*;
#(
    parameter int RUN_LIMIT = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_valid,
    input  logic [1:0] sym_code,
    input  logic       pkt_start,
    output logic       bit_valid,
    output logic       bit_data,
    output logic       stuff_pulse,
    output logic       eop_pulse,
    output logic       stuff_err,
    output logic       line_err
);

    dec_state_t state_q, state_d;
    dec_out_t   out_d, out_q;
    line_sym_t  sym_in;

    logic same_as_prev;
    logic at_limit;
    logic cnt_clear, cnt_incr;
    logic ref_restart, ref_advance;

    assign sym_in = line_sym_t'(sym_code);

    usb_nrzi_prevsym u_prevsym (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (ref_restart),
        .advance      (ref_advance),
        .sym          (sym_in),
        .same_as_prev (same_as_prev)
    );

    usb_nrzi_runlen #(
        .RUN_LIMIT (RUN_LIMIT)
    ) u_runlen (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .incr     (cnt_incr),
        .at_limit (at_limit)
    );

    // Next state, counter control and event decode
    always_comb begin
        state_d     = state_q;
        out_d       = DEC_OUT_NONE;
        cnt_clear   = 1'b0;
        cnt_incr    = 1'b0;
        ref_restart = 1'b0;
        ref_advance = 1'b0;

        if (pkt_start) begin
            // start: from any state, symbol in this cycle dropped
            state_d     = ST_DATA;
            cnt_clear   = 1'b1;
            ref_restart = 1'b1;
        end else if (sym_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_DATA: begin
                    unique case (sym_in)
                        SYM_J, SYM_K: begin
                            ref_advance = 1'b1;
                            if (same_as_prev) begin
                                if (at_limit) begin
                                    // stuff_fault
                                    out_d.stuff_err = 1'b1;
                                    cnt_clear       = 1'b1;
                                    state_d         = ST_IDLE;
                                end else begin
                                    out_d.bit_valid = 1'b1;
                                    out_d.bit_data  = 1'b1;
                                    cnt_incr        = 1'b1;
                                end
                            end else begin
                                cnt_clear = 1'b1;
                                if (at_limit) begin
                                    out_d.stuff = 1'b1;
                                end else begin
                                    out_d.bit_valid = 1'b1;
                                    out_d.bit_data  = 1'b0;
                                end
                            end
                        end
                        SYM_SE0: begin
                            // se0_seen
                            state_d = ST_EOP;
                        end
                        SYM_SE1: begin
                            // line_fault
                            out_d.line_err = 1'b1;
                            cnt_clear      = 1'b1;
                            state_d        = ST_IDLE;
                        end
                        default: state_d = ST_IDLE;
                    endcase
                end
                ST_EOP: begin
                    unique case (sym_in)
                        SYM_SE0: begin
                            // se0_hold
                            state_d = ST_EOP;
                        end
                        SYM_J: begin
                            // eop_done
                            out_d.eop   = 1'b1;
                            cnt_clear   = 1'b1;
                            ref_restart = 1'b1;
                            state_d     = ST_IDLE;
                        end
                        SYM_K, SYM_SE1: begin
                            // line_fault
                            out_d.line_err = 1'b1;
                            cnt_clear      = 1'b1;
                            state_d        = ST_IDLE;
                        end
                        default: state_d = ST_IDLE;
                    endcase
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= DEC_OUT_NONE;
        end else begin
            out_q <= out_d;
        end
    end

    assign bit_valid   = out_q.bit_valid;
    assign bit_data    = out_q.bit_data;
    assign stuff_pulse = out_q.stuff;
    assign eop_pulse   = out_q.eop;
    assign stuff_err   = out_q.stuff_err;
    assign line_err    = out_q.line_err;

    // R10: never two events in one cycle
    assert_single_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_valid, stuff_pulse, eop_pulse, stuff_err, line_err}));

    // R1: a data bit always follows a strobed symbol that was not a restart
    assert_bit_follows_sym_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> ($past(sym_valid) && !$past(pkt_start)));

    // R9: idle symbols leave every output low
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && sym_valid && !pkt_start) |=>
        !(bit_valid || stuff_pulse || eop_pulse || stuff_err || line_err));

    // R7: end of packet only from a J seen while waiting in ST_EOP
    assert_eop_from_j_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pulse |-> ($past(state_q) == ST_EOP && $past(sym_code) == 2'b00));

    // R8: line errors only arise from a symbol inside a packet
    assert_line_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        line_err |-> ($past(sym_valid) && $past(state_q) != ST_IDLE));

    // R11: a restart leaves the machine in ST_DATA
    assert_start_enters_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_start |=> (state_q == ST_DATA));

endmodule

// File: tb/test_usb_nrzi_unstuff.sv
`timescale 1ns/1ps
module test_usb_nrzi_unstuff;

    localparam logic [1:0] CJ = 2'b00, CK = 2'b01, CSE0 = 2'b10, CSE1 = 2'b11;

    typedef enum int { E_NONE, E_B0, E_B1, E_STUFF, E_EOP, E_SERR, E_LERR, E_MULTI } kind_t;
    typedef struct {
        kind_t k;
        int    due;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_valid = 1'b0;
    logic [1:0] sym_code = 2'b00;
    logic pkt_start = 1'b0;
    logic bit_valid, bit_data, stuff_pulse, eop_pulse, stuff_err, line_err;

    int n_vec = 0;
    int n_bad = 0;
    int ncyc = 0;
    bit done = 1'b0;
    exp_t q[$];

    usb_nrzi_unstuff i_usb_nrzi_unstuff (
        .clk         (clk),
        .rst_n       (rst_n),
        .sym_valid   (sym_valid),
        .sym_code    (sym_code),
        .pkt_start   (pkt_start),
        .bit_valid   (bit_valid),
        .bit_data    (bit_data),
        .stuff_pulse (stuff_pulse),
        .eop_pulse   (eop_pulse),
        .stuff_err   (stuff_err),
        .line_err    (line_err)
    );

    always #10 clk = ~clk;

    always @(posedge clk) ncyc <= ncyc + 1;

    function automatic kind_t observe();
        int n;
        n = int'(bit_valid) + int'(stuff_pulse) + int'(eop_pulse) + int'(stuff_err) + int'(line_err);
        if (n > 1) return E_MULTI;
        if (bit_valid) return bit_data ? E_B1 : E_B0;
        if (stuff_pulse) return E_STUFF;
        if (eop_pulse) return E_EOP;
        if (stuff_err) return E_SERR;
        if (line_err) return E_LERR;
        return E_NONE;
    endfunction

    // Monitor: compare each cycle's outputs with the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            kind_t obs;
            obs = observe();
            if (q.size() > 0 && q[0].due == ncyc) begin
                exp_t e;
                e = q.pop_front();
                n_vec++;
                if (obs != e.k) begin
                    n_bad++;
                    $display("FAIL %s: actual=%s expected=%s (cycle %0d)", e.req, obs.name(), e.k.name(), ncyc);
                end
            end else if (obs != E_NONE) begin
                n_vec++;
                n_bad++;
                $display("FAIL R10: actual=%s expected=E_NONE unsolicited (cycle %0d)", obs.name(), ncyc);
            end
        end
    end

    task automatic put_sym(input logic [1:0] c, input kind_t k, input string r);
        sym_valid = 1'b1;
        sym_code  = c;
        q.push_back('{k: k, due: ncyc + 1, req: r});
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    task automatic start_pkt(input string r);
        pkt_start = 1'b1;
        q.push_back('{k: E_NONE, due: ncyc + 1, req: r});
        @(negedge clk);
        pkt_start = 1'b0;
    endtask

    task automatic start_with_sym(input logic [1:0] c, input string r);
        pkt_start = 1'b1;
        sym_valid = 1'b1;
        sym_code  = c;
        q.push_back('{k: E_NONE, due: ncyc + 1, req: r});
        @(negedge clk);
        pkt_start = 1'b0;
        sym_valid = 1'b0;
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_vec++;
            n_bad++;
            $display("FAIL R1: actual=%0d pending expected=0 pending", q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL R10: actual=hung expected=finished (watchdog)");
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        n_vec++;
        if ({bit_valid, bit_data, stuff_pulse, eop_pulse, stuff_err, line_err} != 6'b0) begin
            n_bad++;
            $display("FAIL R10: actual=%b expected=000000 in reset",
                     {bit_valid, bit_data, stuff_pulse, eop_pulse, stuff_err, line_err});
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R9: idle before any start
        put_sym(CK, E_NONE, "R9 idle K");
        put_sym(CJ, E_NONE, "R9 idle J");
        put_sym(CSE1, E_NONE, "R9 idle SE1");

        // R1 / R2: basic NRZI, first K gives 0
        start_pkt("R11 start");
        put_sym(CK, E_B0, "R2 first K");
        put_sym(CK, E_B1, "R1 K repeat");
        put_sym(CJ, E_B0, "R1 K to J");
        repeat (2) @(negedge clk);
        put_sym(CJ, E_B1, "R1 J repeat after gap");
        put_sym(CSE0, E_NONE, "R6 SE0");
        put_sym(CJ, E_EOP, "R7 closing J");
        put_sym(CK, E_NONE, "R9 after EOP");

        // R2: first J gives 1
        start_pkt("R11 start");
        put_sym(CJ, E_B1, "R2 first J");
        put_sym(CSE0, E_NONE, "R6 SE0");
        put_sym(CSE0, E_NONE, "R6 second SE0");
        put_sym(CSE0, E_NONE, "R6 third SE0");
        put_sym(CJ, E_EOP, "R7 EOP after long SE0");

        // R3: six ones then stuff; stuffed symbol becomes reference
        start_pkt("R11 start");
        put_sym(CK, E_B0, "R3 lead 0");
        for (int i = 0; i < 6; i++) put_sym(CK, E_B1, "R3 run of ones");
        put_sym(CJ, E_STUFF, "R3 stuff bit");
        put_sym(CJ, E_B1, "R3 J equals stuffed J");
        put_sym(CK, E_B0, "R4 zero after stuff");
        put_sym(CSE0, E_NONE, "R6 SE0");
        put_sym(CJ, E_EOP, "R7 EOP");

        // R4: five ones then 0 is data; count restarts
        start_pkt("R11 start");
        for (int i = 0; i < 5; i++) put_sym(CJ, E_B1, "R4 five ones");
        put_sym(CK, E_B0, "R4 zero after five ones");
        for (int i = 0; i < 6; i++) put_sym(CK, E_B1, "R4 fresh six ones");
        put_sym(CJ, E_STUFF, "R4 stuff after fresh run");
        put_sym(CSE0, E_NONE, "R6 SE0");
        put_sym(CJ, E_EOP, "R7 EOP");

        // R5: seventh one
        start_pkt("R11 start");
        for (int i = 0; i < 6; i++) put_sym(CJ, E_B1, "R5 six ones");
        put_sym(CJ, E_SERR, "R5 seventh one");
        put_sym(CK, E_NONE, "R5 idle after stuff error");

        // R8: SE1 in data
        start_pkt("R11 start");
        put_sym(CK, E_B0, "R8 lead");
        put_sym(CSE1, E_LERR, "R8 SE1 in data");
        put_sym(CK, E_NONE, "R8 idle after error");

        // R8: K in EOP wait
        start_pkt("R11 start");
        put_sym(CK, E_B0, "R8 lead");
        put_sym(CSE0, E_NONE, "R6 SE0");
        put_sym(CK, E_LERR, "R8 K during EOP");
        put_sym(CJ, E_NONE, "R8 idle after error");

        // R8: SE1 in EOP wait
        start_pkt("R11 start");
        put_sym(CSE0, E_NONE, "R6 SE0 first");
        put_sym(CSE1, E_LERR, "R8 SE1 during EOP");

        // R11: restart mid-packet with coinciding symbol
        start_pkt("R11 start");
        put_sym(CK, E_B0, "R11 lead");
        for (int i = 0; i < 4; i++) put_sym(CK, E_B1, "R11 partial run");
        start_with_sym(CK, "R11 restart drops symbol");
        put_sym(CK, E_B0, "R11 reference back to J");
        for (int i = 0; i < 5; i++) put_sym(CK, E_B1, "R11 count was cleared");
        put_sym(CJ, E_B0, "R11 no stuff after five");
        // R11: restart from EOP wait
        put_sym(CSE0, E_NONE, "R6 SE0");
        start_pkt("R11 restart from EOP");
        put_sym(CK, E_B0, "R11 data after restart");
        put_sym(CSE0, E_NONE, "R6 SE0");
        put_sym(CJ, E_EOP, "R7 EOP");

        finish_run();
    end

endmodule